// File: doc/BRIEF.md
# Shared Message Buffer RAM Arbiter

This block fronts a small word-organised memory that holds the message buffers of a CAN controller. Two masters reach the memory: a CPU port and a protocol-engine port. The memory is single ported internally, so at most one access is performed per clock. When only one port requests, that port is served in the same cycle. When both request together, ownership swaps on every cycle for as long as both keep requesting.

The CPU port accepts 16-bit word and byte writes. Each buffer has a busy flag, raised by the engine while it fills the buffer from a received frame or while the buffer waits to be sent. While a buffer is busy, CPU writes may touch only the low byte of its control/status word. All other bytes of that buffer keep their value. Such a write still completes in one cycle, and the CPU sees a one-cycle flag that reports the suppressed bytes. Reads from either port and writes from the engine port are never restricted.

Top module: `msgbuf_ram_arbiter`

## Requirements
- R1: The word address is {buffer[3:0], offset[2:0]}, giving 15 buffers (0 to 14) of 8 words. Offset 0 is the control/status word, with bits 3:0 the status code, bits 7:4 the transmit priority and bits 11:8 the data length code. Offsets 1 and 2 hold identifiers, offsets 3 to 6 hold data and offset 7 holds the timestamp. Addresses 120 to 127 belong to no buffer: writes to them change nothing and reads from them return 0.
- R2: A granted read returns its word on that port's read-data output in the cycle after the grant. The read-data output holds its value in every cycle in which that port performs no granted read.
- R3: When only one port requests, its ready output is high in that same cycle. A granted write is visible to a read granted in any later cycle.
- R4: While both ports request in consecutive cycles, the ready outputs swap every cycle, and exactly one ready is high in each such cycle.
- R5: In a cycle where both ports request and the previous cycle was not contended, the engine port is granted and the CPU port is not.
- R6: cpu_be[0] enables bits 7:0 and cpu_be[1] enables bits 15:8 of a CPU write. Disabled bytes keep their stored value.
- R7: While buf_busy[n] is high, a CPU write to buffer n stores only bits 7:0 of the offset 0 word. All other bytes of buffer n are left unchanged. Buffers whose busy flag is low are not affected.
- R8: cpu_wr_blocked is high for exactly the one cycle after a granted CPU write in which at least one enabled byte was suppressed, and low otherwise. A blocked write still gets ready in its own cycle.
- R9: Engine-port writes and reads from both ports are permitted regardless of the busy flags.
- R10: While reset is asserted and for two cycles after it is released, both ready outputs are low, even with a request present. cpu_wr_blocked and both read-data outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| buf_busy | input | 15 | Per-buffer busy flags from the engine |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_be | input | 2 | CPU byte enables for writes |
| cpu_addr | input | 7 | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_ready | output | 1 | CPU access performed this cycle |
| cpu_rdata | output | 16 | CPU read data, valid the cycle after a granted read |
| cpu_wr_blocked | output | 1 | One-cycle flag: the last CPU write had bytes suppressed |
| eng_req | input | 1 | Engine access request |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_addr | input | 7 | Engine word address |
| eng_wdata | input | 16 | Engine write data (full word) |
| eng_ready | output | 1 | Engine access performed this cycle |
| eng_rdata | output | 16 | Engine read data, valid the cycle after a granted read |

## Verification
Arbitration and read-data return fall in the same cycles when both ports request together. The bench holds both requests high across several cycles, with each port reading a different preloaded word. It checks the ready pattern cycle by cycle: engine first, then alternating. It also checks that each port's read data carries its own word and is not the other port's. A second contended run follows one CPU-only cycle, to show that a break in contention restarts with the engine. Write protection is also judged at the ports: the bench reads the words back after writes that were suppressed, both fully and in part.

// File: rtl/mbuf_pkg.sv
package mbuf_pkg;
  localparam int MB_NUM_BUF   = 15;
  localparam int MB_BUF_WORDS = 8;
  localparam int MB_DATA_W    = 16;
  localparam int MB_CTRL_OFS  = 0;

  typedef enum logic {
    OWN_ENG = 1'b0,
    OWN_CPU = 1'b1
  } owner_e;
endpackage

// File: rtl/mbuf_arb.sv
module mbuf_arb
  import mbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic eng_req,
  output logic cpu_gnt,
  output logic eng_gnt
);
  logic   both;
  logic   cont_q, cont_d;
  owner_e last_q, last_d, owner;

  always_comb begin
    both   = cpu_req & eng_req;
    owner  = OWN_ENG;
    if (both && cont_q) owner = (last_q == OWN_ENG) ? OWN_CPU : OWN_ENG;
    cpu_gnt = cpu_req & (~eng_req | (owner == OWN_CPU));
    eng_gnt = eng_req & ~cpu_gnt;
    cont_d  = both;
    last_d  = both ? owner : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q <= 1'b0;
      last_q <= OWN_ENG;
    end else begin
      cont_q <= cont_d;
      if (both) last_q <= last_d;
    end
  end

  logic arm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= 1'b1;
  end

  p_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && cpu_req && eng_req && $past(cpu_req && eng_req))
      |-> (cpu_gnt != $past(cpu_gnt)));
  p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && eng_req) |-> (cpu_gnt ^ eng_gnt));
  p_eng_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && cpu_req && eng_req && !$past(cpu_req && eng_req))
      |-> (eng_gnt && !cpu_gnt));
  p_solo_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !eng_req) |-> cpu_gnt);
  p_solo_eng_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !cpu_req) |-> eng_gnt);
endmodule

// File: rtl/mbuf_wprot.sv
module mbuf_wprot
  import mbuf_pkg::*;
#(
  parameter int NUM_BUF   = MB_NUM_BUF,
  parameter int BUF_WORDS = MB_BUF_WORDS,
  parameter int DATA_W    = MB_DATA_W,
  localparam int OFS_W    = $clog2(BUF_WORDS),
  localparam int IDX_W    = $clog2(NUM_BUF + 1),
  localparam int ADDR_W   = OFS_W + IDX_W,
  localparam int BYTES    = DATA_W / 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTES-1:0]   be,
  input  logic [NUM_BUF-1:0] busy,
  output logic [BYTES-1:0]   be_ok,
  output logic               blocked
);
  logic [IDX_W-1:0] idx;
  logic [OFS_W-1:0] ofs;
  logic             hit_busy;
  logic [BYTES-1:0] guard;

  always_comb begin
    idx      = addr[ADDR_W-1:OFS_W];
    ofs      = addr[OFS_W-1:0];
    hit_busy = 1'b0;
    for (int i = 0; i < NUM_BUF; i++)
      if (idx == IDX_W'(i)) hit_busy = busy[i];
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    if (b == 0) begin : g_ctrl
      assign guard[b] = hit_busy & (ofs != OFS_W'(MB_CTRL_OFS));
    end else begin : g_data
      assign guard[b] = hit_busy;
    end
  end

  assign be_ok   = be & ~guard;
  assign blocked = |(be & guard);
endmodule

// File: rtl/mbuf_ram.sv
module mbuf_ram
  import mbuf_pkg::*;
#(
  parameter int NUM_BUF   = MB_NUM_BUF,
  parameter int BUF_WORDS = MB_BUF_WORDS,
  parameter int DATA_W    = MB_DATA_W,
  localparam int OFS_W    = $clog2(BUF_WORDS),
  localparam int IDX_W    = $clog2(NUM_BUF + 1),
  localparam int ADDR_W   = OFS_W + IDX_W,
  localparam int DEPTH    = NUM_BUF * BUF_WORDS,
  localparam int BYTES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_gnt,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTES-1:0]  cpu_be,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              eng_gnt,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] eng_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] addr;
  logic              wr_en, in_range;
  logic [BYTES-1:0]  wbe;
  logic [DATA_W-1:0] wdata, rword;
  logic              cpu_rd, eng_rd;
  logic [DATA_W-1:0] cpu_rdata_d, eng_rdata_d;

  always_comb begin
    addr     = cpu_gnt ? cpu_addr : eng_addr;
    wdata    = cpu_gnt ? cpu_wdata : eng_wdata;
    wbe      = cpu_gnt ? cpu_be : {BYTES{1'b1}};
    wr_en    = (cpu_gnt & cpu_we) | (eng_gnt & eng_we);
    in_range = (int'(addr) < DEPTH);
    rword    = in_range ? mem[addr] : '0;
    cpu_rd   = cpu_gnt & ~cpu_we;
    eng_rd   = eng_gnt & ~eng_we;
    cpu_rdata_d = cpu_rd ? rword : cpu_rdata;
    eng_rdata_d = eng_rd ? rword : eng_rdata;
  end

  always_ff @(posedge clk) begin
    if (wr_en && in_range) begin
      for (int b = 0; b < BYTES; b++)
        if (wbe[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      eng_rdata <= '0;
    end else begin
      cpu_rdata <= cpu_rdata_d;
      eng_rdata <= eng_rdata_d;
    end
  end

  p_cpu_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_gnt && !cpu_we) |=> $stable(cpu_rdata));
  p_eng_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_gnt && !eng_we) |=> $stable(eng_rdata));
endmodule

// File: rtl/msgbuf_ram_arbiter.sv
module msgbuf_ram_arbiter
  import mbuf_pkg::*;
#(
  parameter int NUM_BUF   = MB_NUM_BUF,
  parameter int BUF_WORDS = MB_BUF_WORDS,
  parameter int DATA_W    = MB_DATA_W,
  localparam int OFS_W    = $clog2(BUF_WORDS),
  localparam int IDX_W    = $clog2(NUM_BUF + 1),
  localparam int ADDR_W   = OFS_W + IDX_W,
  localparam int BYTES    = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUF-1:0] buf_busy,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [BYTES-1:0]   cpu_be,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_ready,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_wr_blocked,
  input  logic               eng_req,
  input  logic               eng_we,
  input  logic [ADDR_W-1:0]  eng_addr,
  input  logic [DATA_W-1:0]  eng_wdata,
  output logic               eng_ready,
  output logic [DATA_W-1:0]  eng_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic cpu_gnt, eng_gnt;

  mbuf_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_s),
    .cpu_req (cpu_req & rst_s),
    .eng_req (eng_req & rst_s),
    .cpu_gnt (cpu_gnt),
    .eng_gnt (eng_gnt)
  );

  logic [BYTES-1:0] be_ok;
  logic             wp_blocked;

  mbuf_wprot #(.NUM_BUF(NUM_BUF), .BUF_WORDS(BUF_WORDS), .DATA_W(DATA_W)) u_wprot (
    .addr    (cpu_addr),
    .be      (cpu_be),
    .busy    (buf_busy),
    .be_ok   (be_ok),
    .blocked (wp_blocked)
  );

  mbuf_ram #(.NUM_BUF(NUM_BUF), .BUF_WORDS(BUF_WORDS), .DATA_W(DATA_W)) u_ram (
    .clk       (clk),
    .rst_n     (rst_s),
    .cpu_gnt   (cpu_gnt),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_be    (be_ok),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .eng_gnt   (eng_gnt),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata),
    .eng_rdata (eng_rdata)
  );

  logic blk_d, blk_q;
  always_comb blk_d = cpu_gnt & cpu_we & wp_blocked;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) blk_q <= 1'b0;
    else        blk_q <= blk_d;
  end

  assign cpu_ready      = cpu_gnt;
  assign eng_ready      = eng_gnt;
  assign cpu_wr_blocked = blk_q;

  p_blk_pulse_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (cpu_ready && cpu_we && wp_blocked) |=> cpu_wr_blocked);
  p_blk_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !(cpu_ready && cpu_we) |=> !cpu_wr_blocked);
  p_no_ready_in_reset_r10: assert property (@(posedge clk)
    !rst_s |-> (!cpu_ready && !eng_ready));
endmodule

// File: tb/msgbuf_ram_arbiter_test.sv
module msgbuf_ram_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] buf_busy;
  logic        cpu_req, cpu_we;
  logic [1:0]  cpu_be;
  logic [6:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        cpu_wr_blocked;
  logic        eng_req, eng_we;
  logic [6:0]  eng_addr;
  logic [15:0] eng_wdata;
  logic        eng_ready;
  logic [15:0] eng_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msgbuf_ram_arbiter uut (
    .clk(clk), .rst_n(rst_n), .buf_busy(buf_busy),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .cpu_wr_blocked(cpu_wr_blocked),
    .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_ready(eng_ready), .eng_rdata(eng_rdata)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [6:0] a, logic [15:0] d, logic [1:0] be,
                        output logic rdy, output logic blk);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    #2 rdy = cpu_ready;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    #1 blk = cpu_wr_blocked;
  endtask

  task automatic cpu_rd(logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 0;
    #1 d = cpu_rdata;
  endtask

  task automatic eng_access(logic we, logic [6:0] a, logic [15:0] wd,
                            output logic rdy, output logic [15:0] rd);
    @(negedge clk);
    eng_req = 1; eng_we = we; eng_addr = a; eng_wdata = wd;
    #2 rdy = eng_ready;
    @(negedge clk);
    eng_req = 0; eng_we = 0;
    #1 rd = eng_rdata;
  endtask

  task automatic t_reset();
    rst_n = 0; buf_busy = '0;
    cpu_req = 1; cpu_we = 0; cpu_be = 2'b11; cpu_addr = '0; cpu_wdata = '0;
    eng_req = 1; eng_we = 0; eng_addr = '0; eng_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 cpu_ready in reset", 16'(cpu_ready), 16'h0);
    chk("R10 eng_ready in reset", 16'(eng_ready), 16'h0);
    chk("R10 cpu_rdata reset", cpu_rdata, 16'h0);
    chk("R10 eng_rdata reset", eng_rdata, 16'h0);
    chk("R10 blocked reset", 16'(cpu_wr_blocked), 16'h0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R10 ready held after release", 16'(cpu_ready | eng_ready), 16'h0);
    cpu_req = 0; eng_req = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_basic();
    logic r, b; logic [15:0] d;
    cpu_wr(7'd19, 16'h1357, 2'b11, r, b);
    chk("R3 cpu solo ready", 16'(r), 16'h1);
    eng_access(1'b0, 7'd19, 16'h0, r, d);
    chk("R3 eng solo ready", 16'(r), 16'h1);
    chk("R2 eng reads cpu word", d, 16'h1357);
    cpu_wr(7'd16, 16'h0000, 2'b11, r, b);
    cpu_wr(7'd119, 16'hCAFE, 2'b11, r, b);
    cpu_rd(7'd119, d);
    chk("R1 last word of buffer 14", d, 16'hCAFE);
    repeat (3) @(negedge clk);
    #1 chk("R2 cpu_rdata holds", cpu_rdata, 16'hCAFE);
  endtask

  task automatic t_bytes();
    logic r, b; logic [15:0] d;
    cpu_wr(7'd30, 16'hAAAA, 2'b11, r, b);
    cpu_wr(7'd30, 16'h1234, 2'b01, r, b);
    cpu_rd(7'd30, d);
    chk("R6 low byte write", d, 16'hAA34);
    cpu_wr(7'd30, 16'h5600, 2'b10, r, b);
    cpu_rd(7'd30, d);
    chk("R6 high byte write", d, 16'h5634);
  endtask

  task automatic t_busy();
    logic r, b; logic [15:0] d;
    buf_busy[2] = 1'b1;
    cpu_wr(7'd19, 16'hFFFF, 2'b11, r, b);
    chk("R8 blocked write still ready", 16'(r), 16'h1);
    chk("R8 blocked flag on data word", 16'(b), 16'h1);
    @(negedge clk); #1;
    chk("R8 flag lasts one cycle", 16'(cpu_wr_blocked), 16'h0);
    cpu_rd(7'd19, d);
    chk("R7 data word unchanged", d, 16'h1357);
    cpu_wr(7'd16, 16'hBEEF, 2'b11, r, b);
    chk("R8 flag on partial ctrl write", 16'(b), 16'h1);
    cpu_rd(7'd16, d);
    chk("R7 only ctrl low byte stored", d, 16'h00EF);
    cpu_wr(7'd16, 16'h00A5, 2'b01, r, b);
    chk("R8 no flag on ctrl low byte", 16'(b), 16'h0);
    cpu_rd(7'd16, d);
    chk("R7 ctrl low byte written", d, 16'h00A5);
    cpu_wr(7'd16, 16'h7700, 2'b10, r, b);
    chk("R8 flag on ctrl high byte", 16'(b), 16'h1);
    cpu_rd(7'd16, d);
    chk("R7 ctrl high byte kept", d, 16'h00A5);
    cpu_wr(7'd27, 16'h4444, 2'b11, r, b);
    chk("R7 idle buffer no flag", 16'(b), 16'h0);
    cpu_rd(7'd27, d);
    chk("R7 idle buffer written", d, 16'h4444);
    eng_access(1'b1, 7'd19, 16'h2468, r, d);
    cpu_rd(7'd19, d);
    chk("R9 engine write to busy buffer", d, 16'h2468);
    buf_busy[2] = 1'b0;
    cpu_wr(7'd19, 16'h9999, 2'b11, r, b);
    chk("R7 write after busy clears", 16'(b), 16'h0);
    cpu_rd(7'd19, d);
    chk("R7 word written after busy", d, 16'h9999);
  endtask

  task automatic t_range();
    logic r, b; logic [15:0] d;
    cpu_wr(7'd121, 16'h5555, 2'b11, r, b);
    cpu_rd(7'd121, d);
    chk("R1 unmapped address reads zero", d, 16'h0000);
    cpu_rd(7'd119, d);
    chk("R1 unmapped write no alias", d, 16'hCAFE);
  endtask

  task automatic t_contention();
    logic r, b;
    logic exp_eng [7] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    logic cpu_on  [7] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    logic eng_on  [7] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    cpu_wr(7'd42, 16'h1111, 2'b11, r, b);
    cpu_wr(7'd50, 16'h2222, 2'b11, r, b);
    @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      cpu_req = cpu_on[i]; cpu_we = 0; cpu_addr = 7'd42;
      eng_req = eng_on[i]; eng_we = 0; eng_addr = 7'd50;
      #2;
      if (i == 4) begin
        chk("R3 cpu alone between bursts", 16'(cpu_ready), 16'h1);
      end else if (i == 5) begin
        chk("R5 engine first after break", 16'(eng_ready), 16'h1);
        chk("R5 cpu waits after break", 16'(cpu_ready), 16'h0);
      end else begin
        chk("R4 eng ready pattern", 16'(eng_ready), 16'(exp_eng[i]));
        chk("R4 cpu ready pattern", 16'(cpu_ready), 16'(!exp_eng[i]));
        if (i == 0) chk("R5 engine first on contention", 16'(eng_ready), 16'h1);
      end
      @(negedge clk);
    end
    cpu_req = 0; eng_req = 0;
    #1;
    chk("R2 cpu data under contention", cpu_rdata, 16'h1111);
    chk("R2 eng data under contention", eng_rdata, 16'h2222);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_bytes();
    t_busy();
    t_range();
    t_contention();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule